// File: doc/BRIEF.md
# Delay-Chip Reference Clock Recovery Controller

This block produces the reference clock for a group of delay-locked delay chips. It runs from a system clock at twice the full reference rate. A small register bus selects one of four static output modes: full rate, half rate, quarter rate, or held low. Every mode change is applied at the end of a low phase, so the output never carries a shortened high pulse.

Delay chips can lock onto the wrong multiple of the clock period. For that case the controller offers two timed recovery sequences, each started by a trigger bit in the control register. The first holds the output low for a fixed number of milliseconds. The second runs the output at quarter rate for a programmable number of milliseconds. When either sequence ends, the output returns to full rate without further writes. A busy flag covers each sequence from the trigger until the first full-rate rising edge, and a one-cycle done pulse marks its end.

Top module: `dlyclk_recover`

## Requirements
- R1: After reset the output toggles at full rate, busy and done are 0, address 0 reads 0, and address 1 reads BURST_MS_RST (100).
- R2: With mode field 00 the output has a 2-cycle period: 1 cycle high, 1 cycle low.
- R3: Mode field 01 gives a 4-cycle period (2 high, 2 low). Mode field 10 gives an 8-cycle period (4 high, 4 low).
- R4: Mode field 11 holds the output at 0 for as long as that mode stays selected.
- R5: A new mode is applied only when a low phase ends. Every high phase lasts exactly 1, 2 or 4 cycles, matching the mode it started in, even if a write arrives while the output is high.
- R6: Writing address 0 with bit 2 set starts the hold sequence. Once the current high phase finishes, the output stays at 0 for HOLD_MS × CYC_PER_MS cycles and then resumes at full rate. The mode field reads back as 00.
- R7: Writing address 0 with bit 3 set (and bit 2 clear) starts the burst sequence. The output runs with an 8-cycle period for (address 1 value) × CYC_PER_MS cycles and then resumes at full rate.
- R8: The busy port, also read as bit 4 of address 0, rises on the edge that accepts a trigger. It stays high until the edge on which full-rate output restarts. For the hold sequence that is exactly HOLD_MS × CYC_PER_MS + 1 cycles. The done port pulses high for the single cycle after busy falls.
- R9: While busy, every write to address 0 is ignored: triggers, mode bits and all other bits. If bits 2 and 3 are written together, only the hold sequence starts.
- R10: Address 0 reads the mode in bits [1:0] and busy in bit 4, with all other bits 0. Address 1 reads and writes the burst length in milliseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the full output rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| cond_clk | output | 1 | Conditioned reference clock |
| busy | output | 1 | Recovery sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
Register writes are sampled on one edge. A trigger makes busy visible on the first falling-edge sample after that edge. A static mode change only reaches the output after the current low phase ends, up to 8 cycles later. For that reason the bench waits about ten cycles before it queues expected periods, and it measures each period from one rising sample to the next. Busy is measured as a run of samples taken on the falling edge. The hold sequence must give exactly HOLD_MS × CYC_PER_MS + 1 samples and is checked to the cycle. For the burst, the quarter-rate phase at the end moves the resume point, so the bench accepts a run between 1 and 9 samples longer than the burst length.

// File: rtl/dlyclk_pkg.sv
package dlyclk_pkg;

    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        MODE_FULL = 2'b00,
        MODE_DIV2 = 2'b01,
        MODE_DIV4 = 2'b10,
        MODE_OFF  = 2'b11
    } clk_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_BURST,
        SQ_RESUME
    } seq_state_e;

    typedef struct packed {
        logic [REG_W-6:0] rsvd;
        logic             busy;
        logic             go_burst;
        logic             go_hold;
        clk_mode_e        mode;
    } ctrl_word_t;

    // number of system cycles in one output half period
    function automatic logic [2:0] half_len(clk_mode_e m);
        case (m)
            MODE_DIV2: half_len = 3'd2;
            MODE_DIV4: half_len = 3'd4;
            default:   half_len = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/dlyclk_regs.sv
module dlyclk_regs
    import dlyclk_pkg::*;
#(
    parameter int ADDR_W       = 1,
    parameter int MS_W         = 16,
    parameter int BURST_MS_RST = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    output clk_mode_e         mode,
    output logic [MS_W-1:0]   burst_ms,
    output logic              go_hold,
    output logic              go_burst,
    output logic [REG_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_BURST = ADDR_W'(1);

    clk_mode_e       mode_q;
    logic [MS_W-1:0] burst_q;
    logic            wr_ctrl;
    ctrl_word_t      rd_word;

    always_comb begin
        wr_ctrl  = wr_en && (addr == A_CTRL) && !busy;
        go_hold  = wr_ctrl && wdata[2];
        go_burst = wr_ctrl && wdata[3] && !wdata[2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_FULL;
            burst_q <= MS_W'(BURST_MS_RST);
        end else begin
            if (wr_ctrl) begin
                mode_q <= (wdata[2] || wdata[3]) ? MODE_FULL : clk_mode_e'(wdata[1:0]);
            end
            if (wr_en && addr == A_BURST) begin
                burst_q <= wdata[MS_W-1:0];
            end
        end
    end

    always_comb begin
        rd_word          = '0;
        rd_word.mode     = mode_q;
        rd_word.busy     = busy;
        if (addr == A_CTRL) rdata = rd_word;
        else if (addr == A_BURST) rdata = REG_W'(burst_q);
        else rdata = '0;
    end

    assign mode     = mode_q;
    assign burst_ms = burst_q;

    // R9: no write to the control address changes the mode while busy
    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> (mode_q == $past(mode_q)));

endmodule

// File: rtl/dlyclk_seq.sv
module dlyclk_seq
    import dlyclk_pkg::*;
#(
    parameter int CYC_PER_MS = 80000,
    parameter int HOLD_MS    = 100,
    parameter int MS_W       = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go_hold,
    input  logic            go_burst,
    input  logic [MS_W-1:0] burst_ms,
    input  logic            full_rise,
    input  logic            out_lvl,
    output logic            busy,
    output logic            done,
    output logic            ovr_en,
    output clk_mode_e       ovr_mode
);

    localparam int TICK_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CYC_PER_MS - 1);

    seq_state_e        st_q;
    logic [TICK_W-1:0] tick_q;
    logic [MS_W-1:0]   ms_q;
    logic [MS_W-1:0]   dur_q;
    logic              done_q;
    logic              ms_last;

    assign ms_last = ({1'b0, ms_q} + 1'b1) >= {1'b0, dur_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            tick_q <= '0;
            ms_q   <= '0;
            dur_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                SQ_IDLE: begin
                    tick_q <= '0;
                    ms_q   <= '0;
                    if (go_hold) begin
                        st_q  <= SQ_HOLD;
                        dur_q <= MS_W'(HOLD_MS);
                    end else if (go_burst) begin
                        st_q  <= SQ_BURST;
                        dur_q <= burst_ms;
                    end
                end
                SQ_HOLD, SQ_BURST: begin
                    if (tick_q == TICK_LAST) begin
                        tick_q <= '0;
                        if (ms_last) st_q <= SQ_RESUME;
                        else         ms_q <= ms_q + 1'b1;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: begin
                    if (full_rise) begin
                        st_q   <= SQ_IDLE;
                        done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        ovr_en = (st_q != SQ_IDLE);
        case (st_q)
            SQ_HOLD:  ovr_mode = MODE_OFF;
            SQ_BURST: ovr_mode = MODE_DIV4;
            default:  ovr_mode = MODE_FULL;
        endcase
    end

    assign busy = (st_q != SQ_IDLE);
    assign done = done_q;

    // R6: once low during the hold sequence, the output stays low
    a_r6_hold_stays_low: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_HOLD && !out_lvl) |=> !out_lvl);

    // R9: a running hold sequence cannot be turned into a burst
    a_r9_hold_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_HOLD) |=> (st_q == SQ_HOLD || st_q == SQ_RESUME));

    // R9: a running burst cannot be restarted or turned into a hold
    a_r9_burst_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_BURST) |=> (st_q == SQ_BURST || st_q == SQ_RESUME));

    // R8: done is a single pulse right after busy falls
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy && $past(st_q == SQ_RESUME)));

endmodule

// File: rtl/dlyclk_gen.sv
module dlyclk_gen
    import dlyclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  clk_mode_e req_mode,
    output logic      clk_o,
    output logic      full_rise
);

    clk_mode_e  cur_q;
    logic [2:0] cnt_q;
    logic       out_q;
    logic       phase_end;
    logic       low_decide;

    always_comb begin
        phase_end  = (cnt_q == half_len(cur_q) - 3'd1);
        low_decide = !out_q && (phase_end || cur_q == MODE_OFF);
        full_rise  = low_decide && (req_mode == MODE_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= MODE_FULL;
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (out_q) begin
            if (phase_end) begin
                out_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 3'd1;
            end
        end else if (low_decide) begin
            cur_q <= req_mode;
            cnt_q <= '0;
            out_q <= (req_mode != MODE_OFF);
        end else begin
            cnt_q <= cnt_q + 3'd1;
        end
    end

    assign clk_o = out_q;

    // R5: the active mode only changes while the output is low
    a_r5_switch_when_low: assert property (@(posedge clk) disable iff (rst)
        (cur_q != $past(cur_q)) |-> !$past(out_q));

    // R5: every high phase runs its full length
    a_r5_full_high: assert property (@(posedge clk) disable iff (rst)
        $fell(out_q) |-> ($past(cnt_q) == half_len($past(cur_q)) - 3'd1));

    // R4: in the off mode the output is low
    a_r4_off_low: assert property (@(posedge clk) disable iff (rst)
        (cur_q == MODE_OFF) |-> !out_q);

endmodule

// File: rtl/dlyclk_recover.sv
module dlyclk_recover
    import dlyclk_pkg::*;
#(
    parameter int CYC_PER_MS   = 80000,
    parameter int HOLD_MS      = 100,
    parameter int BURST_MS_RST = 100,
    parameter int MS_W         = 16,
    parameter int ADDR_W       = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              cond_clk,
    output logic              busy,
    output logic              done
);

    clk_mode_e       reg_mode;
    clk_mode_e       ovr_mode;
    clk_mode_e       req_mode;
    logic            ovr_en;
    logic [MS_W-1:0] burst_ms;
    logic            go_hold;
    logic            go_burst;
    logic            full_rise;

    dlyclk_regs #(
        .ADDR_W       (ADDR_W),
        .MS_W         (MS_W),
        .BURST_MS_RST (BURST_MS_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .busy     (busy),
        .mode     (reg_mode),
        .burst_ms (burst_ms),
        .go_hold  (go_hold),
        .go_burst (go_burst),
        .rdata    (rdata)
    );

    dlyclk_seq #(
        .CYC_PER_MS (CYC_PER_MS),
        .HOLD_MS    (HOLD_MS),
        .MS_W       (MS_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go_hold   (go_hold),
        .go_burst  (go_burst),
        .burst_ms  (burst_ms),
        .full_rise (full_rise),
        .out_lvl   (cond_clk),
        .busy      (busy),
        .done      (done),
        .ovr_en    (ovr_en),
        .ovr_mode  (ovr_mode)
    );

    assign req_mode = ovr_en ? ovr_mode : reg_mode;

    dlyclk_gen u_gen (
        .clk       (clk),
        .rst       (rst),
        .req_mode  (req_mode),
        .clk_o     (cond_clk),
        .full_rise (full_rise)
    );

endmodule

// File: tb/tb_dlyclk_recover.sv
`timescale 1ns/1ps
module tb_dlyclk_recover;

    localparam int CPM  = 10;
    localparam int HMS  = 3;
    localparam int HOLD_LEN = HMS * CPM + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [0:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        cond_clk, busy, done;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    int since = 0;
    bit measuring = 0;
    bit prev_out = 0;
    int hi_run = 0;
    int busy_run = 0;
    int last_busy = 0;

    always #2.5 clk = ~clk;

    dlyclk_recover #(.CYC_PER_MS(CPM), .HOLD_MS(HMS)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cond_clk(cond_clk), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[0:0]; wdata = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr = a[0:0];
        #0.5;
        d = int'(rdata);
    endtask

    task automatic drain();
        int g = 0;
        while (exp_q.size() > 0 && g < 1000) begin @(negedge clk); g++; end
        chk(g < 1000, "period queue drained", g, 0);
    endtask

    task automatic wait_idle();
        int g = 0;
        do begin @(negedge clk); g++; end while (busy && g < 2000);
        #0.5;
    endtask

    // scoreboard monitor: periods, high widths, busy runs
    always @(negedge clk) begin
        if (rst) begin
            prev_out = 0; hi_run = 0; busy_run = 0; measuring = 0; since = 0;
        end else begin
            if (cond_clk) hi_run++;
            else if (hi_run > 0) begin
                chk(hi_run == 1 || hi_run == 2 || hi_run == 4, "R5 high width", hi_run, 4);
                hi_run = 0;
            end
            if (cond_clk && !prev_out) begin
                if (measuring) begin
                    chk(since == exp_q[0], "R2/R3/R7 period", since, exp_q[0]);
                    void'(exp_q.pop_front());
                    measuring = 0;
                end
                if (exp_q.size() > 0) begin measuring = 1; since = 0; end
            end
            since++;
            prev_out = cond_clk;
            if (busy) busy_run++;
            else if (busy_run > 0) begin last_busy = busy_run; busy_run = 0; end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int d;
        int highs;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(0, d); chk(d == 0, "R1 ctrl reset", d, 0);
        rd(1, d); chk(d == 100, "R1 burst reset", d, 100);
        chk(busy == 0 && done == 0, "R1 busy/done reset", busy, 0);
        exp_q.push_back(2); exp_q.push_back(2); drain();   // R1 R2

        // R3 divide modes
        wr(0, 1); repeat (10) @(negedge clk);
        exp_q.push_back(4); exp_q.push_back(4); drain();
        wr(0, 2); repeat (10) @(negedge clk);
        exp_q.push_back(8); exp_q.push_back(8); drain();
        rd(0, d); chk(d == 2, "R10 mode readback", d, 2);

        // R4 off, written during a high phase (R5 width checked by monitor)
        while (!cond_clk) @(negedge clk);
        wr(0, 3); repeat (10) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (cond_clk) highs++; end
        chk(highs == 0, "R4 off output high samples", highs, 0);
        wr(0, 0); repeat (4) @(negedge clk);
        exp_q.push_back(2); drain();

        // R10 burst length register
        wr(1, 4); rd(1, d); chk(d == 4, "R10 burst length readback", d, 4);

        // R6 hold from quarter rate, R8 busy timing
        wr(0, 2); repeat (10) @(negedge clk);
        wr(0, 4);
        chk(busy == 1, "R8 busy after trigger", busy, 1);
        repeat (5) @(negedge clk);
        rd(0, d); chk(d == 16, "R8 busy bit readback", d, 16);
        highs = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (cond_clk) highs++; end
        chk(highs == 0, "R6 hold output low", highs, 0);
        wait_idle();
        chk(last_busy == HOLD_LEN, "R8 hold busy length", last_busy, HOLD_LEN);
        chk(done == 1, "R8 done pulse", done, 1);
        @(negedge clk);
        chk(done == 0, "R8 done single cycle", done, 0);
        rd(0, d); chk(d == 0, "R6 mode cleared", d, 0);
        exp_q.push_back(2); drain();

        // R7 burst
        wr(0, 8); repeat (10) @(negedge clk);
        exp_q.push_back(8); exp_q.push_back(8); drain();
        wait_idle();
        chk(last_busy >= 41 && last_busy <= 49, "R7 burst busy length", last_busy, 41);
        exp_q.push_back(2); drain();

        // R9 writes while busy ignored
        wr(0, 4);
        wr(0, 8);
        wr(0, 2);
        wait_idle();
        chk(last_busy == HOLD_LEN, "R9 retrigger ignored", last_busy, HOLD_LEN);
        rd(0, d); chk(d == 0, "R9 mode write ignored", d, 0);
        exp_q.push_back(2); drain();

        // R9 both triggers: hold wins
        wr(0, 12);
        wait_idle();
        chk(last_busy == HOLD_LEN, "R9 hold priority", last_busy, HOLD_LEN);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule